// File: doc/BRIEF.md
# Two-Port Word Store with Cross-Port Doorbells

This block is a 4096-word by 8-bit memory that two agents share. Each agent has its own port with a select, a write strobe, a 12-bit word index, write data and read data. Either port can read or write any word in any cycle, independently of the other port. Everything runs on one clock. Read data is registered: it appears in the cycle after the read is issued and holds until that port reads again.

The two highest word indices also serve as doorbells. Index 0xFFE is the left agent's inbox. Index 0xFFF is the right agent's inbox. When one port writes the other agent's inbox, that agent's active-low interrupt output goes low. The interrupt stays low until its owner reads its own inbox. Both words still hold data like any other word, so a message byte can travel with the interrupt.

Each interrupt comes from a two-state machine. In `FLAG_IDLE` the output is high. The transition *remote-post* (the peer port writes this inbox) moves it to `FLAG_RAISED`, where the output is low. From `FLAG_RAISED`, the transition *local-drain* (the owner port reads its inbox while no remote-post happens in the same cycle) returns it to `FLAG_IDLE`. In every other case the machine stays where it is. Reset puts both machines in `FLAG_IDLE`.

Top module: `mbx_dpram`

## Requirements
- R1: Both ports can write and read all 4096 words. A read issued with select high and write strobe low at one clock edge presents that word on the port's read data after that edge.
- R2: A port's read data keeps its value in every cycle in which that port does not issue a read.
- R3: If one port reads a word in the same cycle that the other port writes it, the read returns the contents from before that write.
- R4: If both ports write the same word in the same cycle, the word keeps the left port's data.
- R5: A right-port write to index 0xFFE drives `l_irq_n` low from the next cycle on.
- R6: A left-port read of index 0xFFE returns `l_irq_n` to high from the next cycle on. A right-port read of that index does not.
- R7: A left-port write to index 0xFFF drives `r_irq_n` low from the next cycle on.
- R8: A right-port read of index 0xFFF returns `r_irq_n` to high from the next cycle on. A left-port read of that index does not.
- R9: If a remote-post and a local-drain reach the same interrupt in the same cycle, the interrupt is low afterwards.
- R10: While reset is held, and in the cycle after it, both interrupt outputs are high and both read data outputs are zero.
- R11: Indices 0xFFE and 0xFFF store data. A read of either returns the last byte written there.
- R12: These actions leave both interrupts unchanged: a port writing its own inbox, any access with select low, and accesses to other indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port access select |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_idx | input | 12 | Left word index |
| l_din | input | 8 | Left write data |
| l_dout | output | 8 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low, push-pull |
| r_sel | input | 1 | Right port access select |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_idx | input | 12 | Right word index |
| r_din | input | 8 | Right write data |
| r_dout | output | 8 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low, push-pull |

## Verification
The clocked properties assume that the select, strobe and index inputs have known values at every edge outside reset. They also assume that the edge which releases reset sees no access on either port, so no access from before reset is still pending when the properties take effect. The stimulus keeps both ports idle until reset is released. It changes inputs only on falling edges, so every rising edge sees stable inputs. The bench sweeps every ordinary index in both directions, and it drives each inbox collision case (same-cycle set and clear, own-inbox write, deselected write) on purpose.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [0:0] {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    localparam int NPORTS = 2;
    localparam int PORT_L = 0;
    localparam int PORT_R = 1;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
    parameter int ADDR_W = 12
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] idx_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic              hit_lbox_o,
    output logic              hit_rbox_o
);
    // Inboxes sit at the two highest indices: top-1 for left, top for right.
    localparam logic [ADDR_W-1:0] LBOX_IDX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RBOX_IDX = {ADDR_W{1'b1}};

    always_comb begin
        rd_en_o    = sel_i & ~wr_i;
        wr_en_o    = sel_i &  wr_i;
        hit_lbox_o = (idx_i == LBOX_IDX);
        hit_rbox_o = (idx_i == RBOX_IDX);
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post_i,
    input  logic drain_i,
    output logic irq_n_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: remote-post and local-drain; a post always wins
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (post_i) begin
                    state_d = FLAG_RAISED;
                end
            end
            FLAG_RAISED: begin
                if (drain_i && !post_i) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        irq_n_o = 1'b1;
        unique case (state_q)
            FLAG_IDLE:   irq_n_o = 1'b1;
            FLAG_RAISED: irq_n_o = 1'b0;
            default:     irq_n_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/mbx_mem.sv
module mbx_mem
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORTS-1:0]              rd_en_i,
    input  logic [NPORTS-1:0]              wr_en_i,
    input  logic [NPORTS-1:0][ADDR_W-1:0]  idx_i,
    input  logic [NPORTS-1:0][DATA_W-1:0]  din_i,
    output logic [NPORTS-1:0][DATA_W-1:0]  dout_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q  [NPORTS];

    // Right is applied first, so the left port's data lands last on a collision
    always_ff @(posedge clk) begin
        if (wr_en_i[PORT_R]) begin
            store[idx_i[PORT_R]] <= din_i[PORT_R];
        end
        if (wr_en_i[PORT_L]) begin
            store[idx_i[PORT_L]] <= din_i[PORT_L];
        end
    end

    // One registered read path per port; reads see contents before this edge
    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q[p] <= '0;
            end else if (rd_en_i[p]) begin
                rd_q[p] <= store[idx_i[p]];
            end
        end
        assign dout_o[p] = rd_q[p];
    end

endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_idx,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_irq_n,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_idx,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_irq_n
);
    logic [NPORTS-1:0]             sel_v;
    logic [NPORTS-1:0]             wr_v;
    logic [NPORTS-1:0][ADDR_W-1:0] idx_v;
    logic [NPORTS-1:0][DATA_W-1:0] din_v;
    logic [NPORTS-1:0][DATA_W-1:0] dout_v;
    logic [NPORTS-1:0]             rd_en;
    logic [NPORTS-1:0]             wr_en;
    logic [NPORTS-1:0]             hit_lbox;
    logic [NPORTS-1:0]             hit_rbox;
    logic [NPORTS-1:0]             post;
    logic [NPORTS-1:0]             drain;
    logic [NPORTS-1:0]             irq_n_v;

    assign sel_v[PORT_L] = l_sel;
    assign sel_v[PORT_R] = r_sel;
    assign wr_v[PORT_L]  = l_wr;
    assign wr_v[PORT_R]  = r_wr;
    assign idx_v[PORT_L] = l_idx;
    assign idx_v[PORT_R] = r_idx;
    assign din_v[PORT_L] = l_din;
    assign din_v[PORT_R] = r_din;

    for (genvar p = 0; p < NPORTS; p++) begin : g_dec
        mbx_port_dec #(.ADDR_W(ADDR_W)) i_dec (
            .sel_i      (sel_v[p]),
            .wr_i       (wr_v[p]),
            .idx_i      (idx_v[p]),
            .rd_en_o    (rd_en[p]),
            .wr_en_o    (wr_en[p]),
            .hit_lbox_o (hit_lbox[p]),
            .hit_rbox_o (hit_rbox[p])
        );
    end

    // Left inbox: peer = right. Right inbox: peer = left.
    assign post[PORT_L]  = wr_en[PORT_R] & hit_lbox[PORT_R];
    assign drain[PORT_L] = rd_en[PORT_L] & hit_lbox[PORT_L];
    assign post[PORT_R]  = wr_en[PORT_L] & hit_rbox[PORT_L];
    assign drain[PORT_R] = rd_en[PORT_R] & hit_rbox[PORT_R];

    for (genvar p = 0; p < NPORTS; p++) begin : g_flag
        mbx_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .post_i  (post[p]),
            .drain_i (drain[p]),
            .irq_n_o (irq_n_v[p])
        );
    end

    mbx_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en),
        .wr_en_i (wr_en),
        .idx_i   (idx_v),
        .din_i   (din_v),
        .dout_o  (dout_v)
    );

    assign l_dout  = dout_v[PORT_L];
    assign r_dout  = dout_v[PORT_R];
    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];

endmodule

// File: rtl/mbx_dpram_chk.sv
module mbx_dpram_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel,
    input logic              l_wr,
    input logic [ADDR_W-1:0] l_idx,
    input logic [DATA_W-1:0] l_dout,
    input logic              l_irq_n,
    input logic              r_sel,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_idx,
    input logic [DATA_W-1:0] r_dout,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] LBOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RBOX = {ADDR_W{1'b1}};

    logic l_rd, r_rd, l_post, l_drain, r_post, r_drain;
    assign l_rd    = l_sel && !l_wr;
    assign r_rd    = r_sel && !r_wr;
    assign l_post  = r_sel && r_wr && (r_idx == LBOX);
    assign l_drain = l_rd && (l_idx == LBOX);
    assign r_post  = l_sel && l_wr && (l_idx == RBOX);
    assign r_drain = r_rd && (r_idx == RBOX);

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n && l_dout == '0 && r_dout == '0));

    p_hold_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_dout));
    p_hold_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_dout));

    p_post_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        l_post |=> !l_irq_n);
    p_drain_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_drain && !l_post) |=> l_irq_n);
    p_post_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_post |=> !r_irq_n);
    p_drain_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_drain && !r_post) |=> r_irq_n);

    p_post_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_post && l_drain) |=> !l_irq_n);

    p_quiet_l_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_post && !l_drain) |=> $stable(l_irq_n));
    p_quiet_r_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_post && !r_drain) |=> $stable(r_irq_n));

endmodule

bind mbx_dpram mbx_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sel   (l_sel),
    .l_wr    (l_wr),
    .l_idx   (l_idx),
    .l_dout  (l_dout),
    .l_irq_n (l_irq_n),
    .r_sel   (r_sel),
    .r_wr    (r_wr),
    .r_idx   (r_idx),
    .r_dout  (r_dout),
    .r_irq_n (r_irq_n)
);

// File: tb/test_mbx_dpram.sv
module test_mbx_dpram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam int NWORDS = 1 << AW;
    localparam logic [AW-1:0] LBOX = 12'hFFE;
    localparam logic [AW-1:0] RBOX = 12'hFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel = 1'b0, l_wr = 1'b0, r_sel = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_idx = '0, r_idx = '0;
    logic [DW-1:0] l_din = '0, r_din = '0;
    logic [DW-1:0] l_dout, r_dout;
    logic          l_irq_n, r_irq_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbx_dpram (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_din(l_din),
        .l_dout(l_dout), .l_irq_n(l_irq_n),
        .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_din(r_din),
        .r_dout(r_dout), .r_irq_n(r_irq_n)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 7 + (a >> 8) + salt);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
    endtask

    // Inputs change on the falling edge; after this the rising edge has consumed them
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic lw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_sel = 1; l_wr = 1; l_idx = a; l_din = d;
    endtask
    task automatic rw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_sel = 1; r_wr = 1; r_idx = a; r_din = d;
    endtask
    task automatic lr(input logic [AW-1:0] a);
        l_sel = 1; l_wr = 0; l_idx = a;
    endtask
    task automatic rr(input logic [AW-1:0] a);
        r_sel = 1; r_wr = 0; r_idx = a;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        @(negedge clk); @(negedge clk);
        // R10: outputs during reset
        check("R10 l_irq_n in reset", l_irq_n, 1);
        check("R10 r_irq_n in reset", r_irq_n, 1);
        check("R10 l_dout in reset", l_dout, 0);
        check("R10 r_dout in reset", r_dout, 0);
        rst_n = 1'b1;
        tick();
        check("R10 l_irq_n after reset", l_irq_n, 1);
        check("R10 r_dout after reset", r_dout, 0);

        // R1: left writes every ordinary word, right reads back
        for (int a = 0; a < NWORDS - 2; a++) begin
            lw(AW'(a), pat(a, 3)); tick();
        end
        idle();
        for (int a = 0; a < NWORDS - 2; a++) begin
            rr(AW'(a)); tick();
            check("R1 right readback", r_dout, pat(a, 3));
        end
        idle();
        // R1: right writes every ordinary word, left reads back
        for (int a = 0; a < NWORDS - 2; a++) begin
            rw(AW'(a), pat(a, 91)); tick();
        end
        idle();
        for (int a = 0; a < NWORDS - 2; a++) begin
            lr(AW'(a)); tick();
            check("R1 left readback", l_dout, pat(a, 91));
        end
        idle();
        // R12: ordinary traffic raised nothing
        check("R12 l_irq_n after sweep", l_irq_n, 1);
        check("R12 r_irq_n after sweep", r_irq_n, 1);

        // R2: read data holds when idle or writing
        held = l_dout;
        tick();
        check("R2 l_dout hold idle", l_dout, held);
        lw(12'h010, 8'h5C); tick(); idle();
        check("R2 l_dout hold on write", l_dout, held);

        // R3: read concurrent with other port's write returns old data
        lw(12'h005, 8'hE1); rr(12'h005); tick(); idle();
        check("R3 read-before-write", r_dout, pat(5, 91));
        rr(12'h005); tick(); idle();
        check("R3 new data after", r_dout, 8'hE1);

        // R4: same-word collision keeps left data
        for (int k = 0; k < 4; k++) begin
            lw(AW'(9 + k * 100), DW'(8'h30 + k)); rw(AW'(9 + k * 100), DW'(8'hC0 + k)); tick(); idle();
            rr(AW'(9 + k * 100)); tick(); idle();
            check("R4 left wins", r_dout, 8'h30 + k);
        end

        // R12: own-inbox writes and deselected writes do not interrupt
        lw(LBOX, 8'h11); rw(RBOX, 8'h22); tick(); idle();
        check("R12 own inbox l", l_irq_n, 1);
        check("R12 own inbox r", r_irq_n, 1);
        l_sel = 0; l_wr = 1; l_idx = RBOX; r_sel = 0; r_wr = 1; r_idx = LBOX; tick(); idle();
        check("R12 deselected l", l_irq_n, 1);
        check("R12 deselected r", r_irq_n, 1);
        // R11: own writes stored
        lr(LBOX); rr(RBOX); tick(); idle();
        check("R11 FFE stored", l_dout, 8'h11);
        check("R11 FFF stored", r_dout, 8'h22);

        // R5 / R6: right posts to left inbox
        rw(LBOX, 8'hA5); tick(); idle();
        check("R5 l_irq_n low", l_irq_n, 0);
        check("R5 r_irq_n unaffected", r_irq_n, 1);
        tick();
        check("R5 l_irq_n stays low", l_irq_n, 0);
        rr(LBOX); tick(); idle();
        check("R6 peer read no clear", l_irq_n, 0);
        check("R11 peer sees FFE", r_dout, 8'hA5);
        lr(LBOX); tick(); idle();
        check("R6 l_irq_n cleared", l_irq_n, 1);
        check("R11 FFE message", l_dout, 8'hA5);

        // R7 / R8: left posts to right inbox
        lw(RBOX, 8'h3C); tick(); idle();
        check("R7 r_irq_n low", r_irq_n, 0);
        check("R7 l_irq_n unaffected", l_irq_n, 1);
        lr(RBOX); tick(); idle();
        check("R8 peer read no clear", r_irq_n, 0);
        rr(RBOX); tick(); idle();
        check("R8 r_irq_n cleared", r_irq_n, 1);
        check("R11 FFF message", r_dout, 8'h3C);

        // R9: post and drain in the same cycle, both directions
        rw(LBOX, 8'h77); lr(LBOX); tick(); idle();
        check("R9 l post wins", l_irq_n, 0);
        check("R3 drain read old FFE", l_dout, 8'hA5);
        lw(RBOX, 8'h88); rr(RBOX); tick(); idle();
        check("R9 r post wins", r_irq_n, 0);
        check("R3 drain read old FFF", r_dout, 8'h3C);
        lr(LBOX); rr(RBOX); tick(); idle();
        check("R6 l cleared after R9", l_irq_n, 1);
        check("R8 r cleared after R9", r_irq_n, 1);
        check("R11 FFE latest", l_dout, 8'h77);
        check("R11 FFF latest", r_dout, 8'h88);

        // R10: reset mid-run clears pending interrupts
        rw(LBOX, 8'h01); lw(RBOX, 8'h02); tick(); idle();
        rst_n = 1'b0; tick();
        check("R10 l_irq_n reset", l_irq_n, 1);
        check("R10 r_irq_n reset", r_irq_n, 1);
        check("R10 l_dout reset", l_dout, 0);
        rst_n = 1'b1; tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule